// File: doc/BRIEF.md
# Two-Wire Serial Eight-Channel DAC Latch Bank

This block is a write-only slave on a two-wire serial bus. It holds the digital codes for eight 8-bit DAC channels. The block samples SCL and SDA with the system clock, which must run much faster than the bus, and finds START and STOP conditions and the bit edges from those samples. After a START it compares the first byte with its own 7-bit address. If the address matches and the byte asks for a write, the block acknowledges it. Command bytes and data bytes then follow in pairs, and the block acknowledges each of them too.

Each channel has two registers: an input (staging) latch and an output latch. A data byte goes only into the input latch of the channel that the command byte before it selected. The output latches, and the power-down and reset requests, change only at STOP. At that point all eight outputs change in the same cycle. The last command byte of a transfer decides the power-down and reset requests.

The link state machine has these states:
- `ST_IDLE`: the bus is idle.
- `ST_ADDR`: shifting in the address byte.
- `ST_ADDR_ACK`: acknowledging the address.
- `ST_CMD`: shifting in a command byte.
- `ST_CMD_ACK`: acknowledging a command byte.
- `ST_DATA`: shifting in a data byte.
- `ST_DATA_ACK`: acknowledging a data byte.
- `ST_SKIP`: ignoring the bus until the next START or STOP.

The transitions are:
- From any state, STOP goes to `ST_IDLE` and START goes to `ST_ADDR`.
- At the eighth bit, `ST_ADDR` goes to `ST_ADDR_ACK` if the address matches and to `ST_SKIP` if it does not.
- At the eighth bit, `ST_CMD` goes to `ST_CMD_ACK` and `ST_DATA` goes to `ST_DATA_ACK`.
- When SCL falls at the end of the acknowledge pulse, `ST_ADDR_ACK` goes to `ST_CMD`, `ST_CMD_ACK` goes to `ST_DATA`, and `ST_DATA_ACK` goes back to `ST_CMD`.

Top module: `twb_dac_bank`

## Requirements
- R1: After reset, every output code is 0x00, `pwr_down` is 0 and `sda_oe` is 0.
- R2: The block accepts an address byte only when its upper seven bits equal `0101 0` followed by `addr_sel[1]` and `addr_sel[0]`, and its LSB (the write flag) is 0. Any other byte, including a read request to the matching address, gets no acknowledge and changes nothing.
- R3: For every accepted byte (address, command or data), `sda_oe` is 1 during the ninth SCL high phase and is released to 0 after the ninth SCL falling edge.
- R4: In a command byte, bit 4 is the reset request, bit 3 is the power-down request and bits 2..0 select a channel. Bits 7..5 are ignored.
- R5: A data byte goes into the input latch of the channel that the preceding command byte selected. No output code changes before STOP.
- R6: At STOP after an addressed transfer, every input latch is copied into its output latch in the same clock cycle.
- R7: The power-down bit of the last command byte in a transfer sets `pwr_down` at STOP. An earlier command byte in the same transfer has no effect on it. The channel bits of a command byte that has no data byte after it write nothing.
- R8: If the last command byte of a transfer has the reset bit set, then at STOP every input latch and every output latch is cleared to 0x00, even if that transfer wrote data.
- R9: A repeated START changes no output. It begins a new address phase, and the transfer is committed only at the following STOP.
- R10: A STOP that ends a transfer whose address phase was never accepted leaves all outputs and `pwr_down` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as sampled |
| sda_i | input | 1 | Serial data line as sampled (wired-AND level) |
| addr_sel | input | 2 | Selects the two lowest bits of the slave address |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| dac_codes | output | 64 | Output-latch codes; channel c is at bits [8c+7:8c] |
| pwr_down | output | 1 | Power-down state applied at the last STOP |

## Verification
The assertions assume that the bus obeys the two-wire rules at the sample rate. SDA changes only while SCL is low, except for START and STOP. Each SCL level is held for several system clocks longer than the synchronizer delay. The bench drives the bus with a quarter-bit time of eight clocks. It models SDA as the wired-AND of the master's drive and the block's `sda_oe`, and it changes SDA only in the middle of the SCL low phase. The acknowledge-timing assertion, and the rule that outputs change only at STOP, both rely on those clean edges.

// File: rtl/twb_pkg.sv
package twb_pkg;
    localparam int BYTE_W     = 8;
    localparam int CH_NUM     = 8;
    localparam int SEL_W      = $clog2(CH_NUM);
    localparam int PIN_W      = 2;
    localparam logic [4:0] ADDR_FIXED = 5'b01010;
    localparam int CMD_RST_BIT = 4;
    localparam int CMD_PD_BIT  = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_SKIP
    } link_state_t;
endpackage

// File: rtl/twb_line_sync.sv
module twb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_p;
    logic              sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_p  <= scl_ff[STAGES-1];
            sda_p  <= sda_ff[STAGES-1];
        end
    end

    assign scl_s     = scl_ff[STAGES-1];
    assign sda_s     = sda_ff[STAGES-1];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/twb_link_fsm.sv
module twb_link_fsm
    import twb_pkg::*;
#(
    parameter int BITS = BYTE_W,
    parameter int PINS = PIN_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_s,
    input  logic            sda_s,
    input  logic            scl_rise,
    input  logic            scl_fall,
    input  logic            start_det,
    input  logic            stop_det,
    input  logic [PINS-1:0] addr_sel,
    output logic            sda_oe,
    output logic            addr_ok,
    output logic            cmd_stb,
    output logic            data_stb,
    output logic [BITS-1:0] byte_q
);
    localparam int CNT_W = $clog2(BITS + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BITS);

    link_state_t      st, st_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [BITS-1:0]  sh, sh_n;
    logic             addr_hit;
    logic             byte_done;

    assign addr_hit  = (sh == {ADDR_FIXED, addr_sel, 1'b0});
    assign byte_done = scl_fall && (cnt == LAST_CNT) && !start_det && !stop_det;

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        sh_n  = sh;
        if (stop_det) begin
            st_n  = ST_IDLE;
            cnt_n = '0;
        end else if (start_det) begin
            st_n  = ST_ADDR;
            cnt_n = '0;
        end else begin
            unique case (st)
                ST_IDLE, ST_SKIP: begin
                    st_n = st;
                end
                ST_ADDR, ST_CMD, ST_DATA: begin
                    if (scl_rise && cnt != LAST_CNT) begin
                        sh_n  = {sh[BITS-2:0], sda_s};
                        cnt_n = cnt + 1'b1;
                    end else if (byte_done) begin
                        cnt_n = '0;
                        if (st == ST_ADDR)
                            st_n = addr_hit ? ST_ADDR_ACK : ST_SKIP;
                        else if (st == ST_CMD)
                            st_n = ST_CMD_ACK;
                        else
                            st_n = ST_DATA_ACK;
                    end
                end
                ST_ADDR_ACK: if (scl_fall) st_n = ST_CMD;
                ST_CMD_ACK:  if (scl_fall) st_n = ST_DATA;
                ST_DATA_ACK: if (scl_fall) st_n = ST_CMD;
                default:     st_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
            sh  <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
            sh  <= sh_n;
        end
    end

    always_comb begin
        sda_oe   = 1'b0;
        addr_ok  = 1'b0;
        cmd_stb  = 1'b0;
        data_stb = 1'b0;
        unique case (st)
            ST_ADDR_ACK, ST_CMD_ACK, ST_DATA_ACK: sda_oe = 1'b1;
            ST_ADDR: addr_ok  = byte_done && addr_hit;
            ST_CMD:  cmd_stb  = byte_done;
            ST_DATA: data_stb = byte_done;
            default: sda_oe = 1'b0;
        endcase
    end

    assign byte_q = sh;

    // R3: the acknowledge drive only moves while SCL is low
    a_r3_ack_edge_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s);

    // R4: at most one byte event per cycle
    a_r4_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({addr_ok, cmd_stb, data_stb}));

    // R2: an address acknowledge begins only after a matching address byte
    a_r2_ack_after_match: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ADDR_ACK && $past(st) == ST_ADDR) |-> $past(addr_ok));
endmodule

// File: rtl/twb_latch_bank.sv
module twb_latch_bank
    import twb_pkg::*;
#(
    parameter int NUM_CH = CH_NUM,
    parameter int DW     = BYTE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               addr_ok,
    input  logic               cmd_stb,
    input  logic               data_stb,
    input  logic [DW-1:0]      byte_i,
    input  logic               stop_det,
    output logic [NUM_CH*DW-1:0] dac_codes,
    output logic               pwr_down
);
    localparam int SW = $clog2(NUM_CH);

    logic [DW-1:0] in_q  [NUM_CH];
    logic [DW-1:0] out_q [NUM_CH];
    logic [SW-1:0] sel_q;
    logic          pend_pd;
    logic          pend_rst;
    logic          cmd_seen;
    logic          addressed;
    logic          do_commit;
    logic          do_clear;

    assign do_commit = stop_det && addressed;
    assign do_clear  = do_commit && cmd_seen && pend_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q     <= '0;
            pend_pd   <= 1'b0;
            pend_rst  <= 1'b0;
            cmd_seen  <= 1'b0;
            addressed <= 1'b0;
            pwr_down  <= 1'b0;
        end else if (stop_det) begin
            if (do_commit && cmd_seen) pwr_down <= pend_pd;
            pend_pd   <= 1'b0;
            pend_rst  <= 1'b0;
            cmd_seen  <= 1'b0;
            addressed <= 1'b0;
        end else begin
            if (addr_ok) addressed <= 1'b1;
            if (cmd_stb) begin
                sel_q    <= byte_i[SW-1:0];
                pend_pd  <= byte_i[CMD_PD_BIT];
                pend_rst <= byte_i[CMD_RST_BIT];
                cmd_seen <= 1'b1;
            end
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                in_q[c]  <= '0;
                out_q[c] <= '0;
            end else if (do_clear) begin
                in_q[c]  <= '0;
                out_q[c] <= '0;
            end else begin
                if (do_commit) out_q[c] <= in_q[c];
                if (data_stb && sel_q == SW'(c)) in_q[c] <= byte_i;
            end
        end
        assign dac_codes[c*DW +: DW] = out_q[c];
    end

    // R6: output codes move only in the cycle after a STOP
    a_r6_codes_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_codes != $past(dac_codes)) |-> $past(stop_det));

    // R7: power-down moves only after a STOP
    a_r7_pd_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_down != $past(pwr_down)) |-> $past(stop_det));

    // R8: a pending reset empties every output
    a_r8_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && addressed && cmd_seen && pend_rst) |=> (dac_codes == '0));

    // R10: a transfer that was never addressed commits nothing
    a_r10_unaddressed_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !addressed) |=> ($stable(dac_codes) && $stable(pwr_down)));
endmodule

// File: rtl/twb_dac_bank.sv
module twb_dac_bank
    import twb_pkg::*;
#(
    parameter int NUM_CH      = CH_NUM,
    parameter int DW          = BYTE_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_i,
    input  logic                 sda_i,
    input  logic [PIN_W-1:0]     addr_sel,
    output logic                 sda_oe,
    output logic [NUM_CH*DW-1:0] dac_codes,
    output logic                 pwr_down
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic addr_ok, cmd_stb, data_stb;
    logic [DW-1:0] byte_q;

    twb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    twb_link_fsm #(.BITS(DW), .PINS(PIN_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .addr_sel(addr_sel),
        .sda_oe(sda_oe), .addr_ok(addr_ok), .cmd_stb(cmd_stb),
        .data_stb(data_stb), .byte_q(byte_q)
    );

    twb_latch_bank #(.NUM_CH(NUM_CH), .DW(DW)) u_bank (
        .clk(clk), .rst_n(rst_n), .addr_ok(addr_ok), .cmd_stb(cmd_stb),
        .data_stb(data_stb), .byte_i(byte_q), .stop_det(stop_det),
        .dac_codes(dac_codes), .pwr_down(pwr_down)
    );
endmodule

// File: tb/tb_twb_dac_bank.sv
module tb_twb_dac_bank;
    localparam int Q = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic [1:0]  asel = 2'b10;
    logic        sda_oe;
    logic [63:0] codes;
    logic        pd;
    wire         sda_line = sda_m & ~sda_oe;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic [7:0] exp_in [8];
    logic [7:0] exp_out [8];
    logic       exp_pd;

    always #2 clk = ~clk;

    twb_dac_bank dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .addr_sel(asel), .sda_oe(sda_oe), .dac_codes(codes), .pwr_down(pd)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_codes();
        logic [63:0] v;
        for (int c = 0; c < 8; c++) v[c*8 +: 8] = exp_out[c];
        return v;
    endfunction

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b0; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b1; tick(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked, output logic released);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl = 1'b1;   tick(2 * Q);
            scl = 1'b0;   tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        acked = ~sda_line;
        tick(Q);
        scl = 1'b0;   tick(Q);
        released = ~sda_oe;
    endtask

    task automatic send_chk(input string req, input logic [7:0] b, input logic exp_ack);
        logic a, r;
        send_byte(b, a, r);
        chk(req, {63'd0, a}, {63'd0, exp_ack});
        if (exp_ack) chk("R3 release", {63'd0, r}, 64'd1);
    endtask

    task automatic pair(input logic [2:0] ch, input logic [7:0] v, input logic pdb, input logic rstb);
        send_chk("R3 cmd ack", {3'b101, rstb, pdb, ch}, 1'b1);
        send_chk("R3 data ack", v, 1'b1);
        exp_in[ch] = v;
    endtask

    task automatic commit(input logic last_pd, input logic last_rst, input logic had_cmd);
        if (had_cmd && last_rst) begin
            for (int c = 0; c < 8; c++) begin exp_in[c] = 8'h00; exp_out[c] = 8'h00; end
        end else begin
            for (int c = 0; c < 8; c++) exp_out[c] = exp_in[c];
        end
        if (had_cmd) exp_pd = last_pd;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 8; c++) begin exp_in[c] = 0; exp_out[c] = 0; end
        exp_pd = 0;
        tick(5);
        chk("R1 codes", codes, 64'd0);
        chk("R1 pd", {63'd0, pd}, 64'd0);
        chk("R1 oe", {63'd0, sda_oe}, 64'd0);
        rst_n = 1'b1;
        tick(5);

        // R2: sweep every 7-bit address with the write flag, selector 2'b10
        for (int a = 0; a < 128; a++) begin
            bus_start();
            send_chk("R2 addr sweep", {a[6:0], 1'b0}, (a[6:0] == {5'b01010, asel}));
            bus_stop();
        end
        // R2: read request to own address is refused
        bus_start();
        send_chk("R2 read refused", {5'b01010, asel, 1'b1}, 1'b0);
        bus_stop();
        // R2: every selector value
        for (int s = 0; s < 4; s++) begin
            asel = s[1:0];
            bus_start();
            send_chk("R2 selector match", {5'b01010, s[1:0], 1'b0}, 1'b1);
            bus_stop();
            bus_start();
            send_chk("R2 selector miss", {5'b01010, ~s[1:0], 1'b0}, 1'b0);
            bus_stop();
        end
        asel = 2'b01;
        chk("R10 sweep left codes", codes, exp_codes());

        // R4 R5 R6: fill all channels, outputs wait for STOP
        bus_start();
        send_chk("R2 addr", 8'b0101_0010, 1'b1);
        for (int c = 0; c < 8; c++) pair(c[2:0], 8'(c * 37 + 5), 1'b0, 1'b0);
        chk("R5 no change before stop", codes, 64'd0);
        bus_stop();
        commit(1'b0, 1'b0, 1'b1);
        chk("R6 all channels", codes, exp_codes());
        chk("R4 pd low", {63'd0, pd}, 64'd0);

        // R7: earlier PD overwritten; trailing command only sets PD
        bus_start();
        send_chk("R2 addr", 8'b0101_0010, 1'b1);
        pair(3'd3, 8'hAA, 1'b0, 1'b0);
        pair(3'd1, 8'h3C, 1'b1, 1'b0);
        send_chk("R7 trailing cmd ack", 8'b0000_1101, 1'b1);
        bus_stop();
        commit(1'b1, 1'b0, 1'b1);
        chk("R7 codes trailing ch ignored", codes, exp_codes());
        chk("R7 pd set", {63'd0, pd}, 64'd1);

        bus_start();
        send_chk("R2 addr", 8'b0101_0010, 1'b1);
        pair(3'd6, 8'h5A, 1'b1, 1'b0);
        send_chk("R7 trailing cmd ack", 8'b0000_0110, 1'b1);
        bus_stop();
        commit(1'b0, 1'b0, 1'b1);
        chk("R7 pd cleared by last", {63'd0, pd}, 64'd0);
        chk("R7 codes", codes, exp_codes());

        // R9: repeated START does not commit
        bus_start();
        send_chk("R2 addr", 8'b0101_0010, 1'b1);
        pair(3'd2, 8'h11, 1'b0, 1'b0);
        bus_start();
        chk("R9 no commit at restart", codes, exp_codes());
        send_chk("R9 readdress", 8'b0101_0010, 1'b1);
        pair(3'd7, 8'hE7, 1'b0, 1'b0);
        chk("R9 still held", codes, exp_codes());
        bus_stop();
        commit(1'b0, 1'b0, 1'b1);
        chk("R9 commit at stop", codes, exp_codes());

        // R10: unaddressed transfer commits nothing
        bus_start();
        send_chk("R10 wrong addr", 8'b0101_1110, 1'b0);
        send_chk("R10 ignored cmd", 8'b0000_1000, 1'b0);
        send_chk("R10 ignored data", 8'hFF, 1'b0);
        bus_stop();
        chk("R10 codes held", codes, exp_codes());
        chk("R10 pd held", {63'd0, pd}, {63'd0, exp_pd});

        // R8: reset request overrides data of this transfer
        bus_start();
        send_chk("R2 addr", 8'b0101_0010, 1'b1);
        pair(3'd4, 8'h99, 1'b0, 1'b0);
        send_chk("R8 rst cmd ack", 8'b0001_0000, 1'b1);
        bus_stop();
        commit(1'b0, 1'b1, 1'b1);
        chk("R8 cleared", codes, 64'd0);
        bus_start();
        send_chk("R2 addr", 8'b0101_0010, 1'b1);
        bus_stop();
        commit(1'b0, 1'b0, 1'b0);
        chk("R8 input latches cleared", codes, 64'd0);
        chk("R8 pd", {63'd0, pd}, {63'd0, exp_pd});

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule